// File: doc/BRIEF.md
# Register Preload and Observation Controller

This block gives a test controller direct access to a bank of paired state registers. Each cell owns a first register (Q1, the one that normally drives the pin) and a buried second register (Q2). Cells come in even/odd pairs: cell 2k is the even member of pair k and cell 2k+1 the odd member. While preload is requested, a rising edge on the preload strobe copies the level on each pair's odd data pin into one chosen register of that pair. All pairs load at the same time. The choice of register is made by two select bits. Stored values are raw data levels, so they are not affected by output inversion or output source selection.

While observation is requested, each cell whose output enable is high shows its buried Q2 on its output. When neither mode is active, every output carries its normal data: Q1 or the cell's combinational input, each optionally inverted. A one-way lock disables both test modes. It acts in the same cycle it is asserted, and only a controller reset clears it. Mode entry arrives as plain digital request inputs. The functional logic that computes the next register values lies outside this block and reaches it through per-cell data inputs.

Top module: `tam_preload_ctrl`

## Requirements
- R1: After rst_ni is released, every Q1 and Q2 bit is 0 and lock_o is 0.
- R2: A preload write stores the level of odd pin 2k+1 into the selected register of pair k, for every pair k at once, with no regard to inv_i or comb_sel_i.
- R3: The select code {q_sel_i, par_sel_i} picks the register: 2'b00 writes even Q1 (cell 2k), 2'b01 writes odd Q1 (cell 2k+1), 2'b10 writes even Q2, and 2'b11 writes odd Q2.
- R4: Registers outside the selected group keep their values through a preload write.
- R5: A write happens only at a clock edge where strobe_i is sampled 1 after being sampled 0, and only if preload_req_i is 1. A strobe that stays high writes once. A strobe while preload_req_i is 0 changes nothing.
- R6: inv_i and comb_sel_i have no effect on the value that a preload write stores.
- R7: While observe_req_i is 1 and the lock is inactive, out_o[i] equals Q2 of cell i wherever oe_i[i] is 1. Cells with oe_i[i] at 0 keep their normal data.
- R8: A one-cycle pulse on lock_set_i sets lock_o from the next cycle until reset. While the lock is set, preload strobes write nothing and outputs show normal data.
- R9: The lock takes effect in the very cycle lock_set_i is high: a strobe edge in that cycle writes nothing, and observation is already suppressed on out_o.
- R10: When observation is off, out_o[i] = (comb_sel_i[i] ? comb_i[i] : Q1[i]) XOR inv_i[i].
- R11: func_en_i loads d1_i into Q1 and d2_i into Q2 at the next edge, but only while preload_req_i is 0.
- R12: out_en_o follows oe_i in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preload_req_i | input | 1 | Preload mode request |
| observe_req_i | input | 1 | Buried-register observation request |
| strobe_i | input | 1 | Preload strobe; a rising edge writes |
| q_sel_i | input | 1 | Register select: 0 = Q1, 1 = Q2 |
| par_sel_i | input | 1 | Parity select: 0 = even cells, 1 = odd cells |
| lock_set_i | input | 1 | Security lock set pulse |
| pin_i | input | N_CELLS | Pin levels; odd bits carry preload data |
| func_en_i | input | 1 | Functional register load enable |
| d1_i | input | N_CELLS | Functional next value for Q1 |
| d2_i | input | N_CELLS | Functional next value for Q2 |
| comb_sel_i | input | N_CELLS | Per-cell normal source: 1 = comb_i, 0 = Q1 |
| comb_i | input | N_CELLS | Combinational data per cell |
| inv_i | input | N_CELLS | Output inversion per cell |
| oe_i | input | N_CELLS | Output enable per cell |
| out_o | output | N_CELLS | Output data |
| out_en_o | output | N_CELLS | Output enable to the pin buffer |
| q1_fb_o | output | N_CELLS | Q1 feedback |
| q2_fb_o | output | N_CELLS | Q2 feedback |
| lock_o | output | 1 | Security lock state |

## Verification
The bench builds the controller with N_CELLS = 8, which gives four pairs. Each select code then writes a four-bit group, so one check can see a whole group written and the other three groups left alone. Pin patterns in which even and odd bits disagree show that only odd pins supply data and that each datum lands in the right cell. The same width keeps mixed output-enable, inversion and source-select patterns small enough to work out by hand, in every mode and while the lock is set.

// File: rtl/tam_pkg.sv
package tam_pkg;
  // encoding is {q_sel, par_sel}
  typedef enum logic [1:0] {
    GRP_EVEN_Q1 = 2'b00,
    GRP_ODD_Q1  = 2'b01,
    GRP_EVEN_Q2 = 2'b10,
    GRP_ODD_Q2  = 2'b11
  } grp_e;

  localparam int unsigned NUM_GRP = 4;
endpackage

// File: rtl/tam_group_dec.sv
module tam_group_dec
  import tam_pkg::*;
(
  input  logic                 wr_i,
  input  logic                 q_sel_i,
  input  logic                 par_sel_i,
  output logic [NUM_GRP-1:0]   grp_wr_o
);
  grp_e grp;
  assign grp = grp_e'({q_sel_i, par_sel_i});

  always_comb begin
    grp_wr_o = '0;
    if (wr_i) grp_wr_o[grp] = 1'b1;
  end
endmodule

// File: rtl/tam_strobe_edge.sv
module tam_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/tam_lock.sv
module tam_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic locked_o,
  output logic active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    locked_o <= 1'b0;
    else if (set_i) locked_o <= 1'b1;
  end

  // set acts in its own cycle
  assign active_o = locked_o | set_i;
endmodule

// File: rtl/tam_cell_pair.sv
module tam_cell_pair
  import tam_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_odd_i,
  input  logic [NUM_GRP-1:0] grp_wr_i,
  input  logic               func_en_i,
  input  logic [1:0]         d1_i,
  input  logic [1:0]         d2_i,
  output logic [1:0]         q1_o,
  output logic [1:0]         q2_o
);
  // index 0 = even cell, 1 = odd cell
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q1_o <= '0;
      q2_o <= '0;
    end else if (func_en_i) begin
      q1_o <= d1_i;
      q2_o <= d2_i;
    end else begin
      if (grp_wr_i[GRP_EVEN_Q1]) q1_o[0] <= pin_odd_i;
      if (grp_wr_i[GRP_ODD_Q1])  q1_o[1] <= pin_odd_i;
      if (grp_wr_i[GRP_EVEN_Q2]) q2_o[0] <= pin_odd_i;
      if (grp_wr_i[GRP_ODD_Q2])  q2_o[1] <= pin_odd_i;
    end
  end
endmodule

// File: rtl/tam_preload_ctrl.sv
module tam_preload_ctrl
  import tam_pkg::*;
#(
  parameter int unsigned N_CELLS = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               preload_req_i,
  input  logic               observe_req_i,
  input  logic               strobe_i,
  input  logic               q_sel_i,
  input  logic               par_sel_i,
  input  logic               lock_set_i,
  input  logic [N_CELLS-1:0] pin_i,
  input  logic               func_en_i,
  input  logic [N_CELLS-1:0] d1_i,
  input  logic [N_CELLS-1:0] d2_i,
  input  logic [N_CELLS-1:0] comb_sel_i,
  input  logic [N_CELLS-1:0] comb_i,
  input  logic [N_CELLS-1:0] inv_i,
  input  logic [N_CELLS-1:0] oe_i,
  output logic [N_CELLS-1:0] out_o,
  output logic [N_CELLS-1:0] out_en_o,
  output logic [N_CELLS-1:0] q1_fb_o,
  output logic [N_CELLS-1:0] q2_fb_o,
  output logic               lock_o
);
  localparam int unsigned N_PAIRS = N_CELLS / 2;

  logic               rise;
  logic               lock_active;
  logic               wr;
  logic               func_ok;
  logic               obs_on;
  logic [NUM_GRP-1:0] grp_wr;

  tam_strobe_edge i_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .rise_o   (rise)
  );

  tam_lock i_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (lock_set_i),
    .locked_o (lock_o),
    .active_o (lock_active)
  );

  assign wr      = rise & preload_req_i & ~lock_active;
  assign func_ok = func_en_i & ~preload_req_i;
  assign obs_on  = observe_req_i & ~lock_active;

  tam_group_dec i_dec (
    .wr_i      (wr),
    .q_sel_i   (q_sel_i),
    .par_sel_i (par_sel_i),
    .grp_wr_o  (grp_wr)
  );

  for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
    tam_cell_pair i_pair (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_odd_i (pin_i[2*k+1]),
      .grp_wr_i  (grp_wr),
      .func_en_i (func_ok),
      .d1_i      (d1_i[2*k+:2]),
      .d2_i      (d2_i[2*k+:2]),
      .q1_o      (q1_fb_o[2*k+:2]),
      .q2_o      (q2_fb_o[2*k+:2])
    );
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_out
    logic norm;
    assign norm        = (comb_sel_i[i] ? comb_i[i] : q1_fb_o[i]) ^ inv_i[i];
    assign out_o[i]    = (obs_on & oe_i[i]) ? q2_fb_o[i] : norm;
    assign out_en_o[i] = oe_i[i];
  end
endmodule

// File: rtl/tam_preload_chk.sv
module tam_preload_chk #(
  parameter int unsigned N_CELLS = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               preload_req_i,
  input logic               observe_req_i,
  input logic               strobe_i,
  input logic               q_sel_i,
  input logic               par_sel_i,
  input logic               lock_set_i,
  input logic [N_CELLS-1:0] pin_i,
  input logic               func_en_i,
  input logic [N_CELLS-1:0] oe_i,
  input logic [N_CELLS-1:0] out_o,
  input logic [N_CELLS-1:0] q1_fb_o,
  input logic [N_CELLS-1:0] q2_fb_o,
  input logic               lock_o
);
  localparam int unsigned N_PAIRS = N_CELLS / 2;

  function automatic logic [N_PAIRS-1:0] evens(input logic [N_CELLS-1:0] x);
    for (int k = 0; k < N_PAIRS; k++) evens[k] = x[2*k];
  endfunction

  function automatic logic [N_PAIRS-1:0] odds(input logic [N_CELLS-1:0] x);
    for (int k = 0; k < N_PAIRS; k++) odds[k] = x[2*k+1];
  endfunction

  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);

  assert_lock_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_set_i |=> lock_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!func_en_i && !$rose(strobe_i)) |=> ($stable(q1_fb_o) && $stable(q2_fb_o)));

  assert_locked_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lock_o || lock_set_i) && !func_en_i) |=> ($stable(q1_fb_o) && $stable(q2_fb_o)));

  assert_even_q1_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(strobe_i) && preload_req_i && !lock_o && !lock_set_i && !q_sel_i && !par_sel_i)
    |=> (evens(q1_fb_o) == odds($past(pin_i))));

  assert_odd_q2_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(strobe_i) && preload_req_i && !lock_o && !lock_set_i && q_sel_i && par_sel_i)
    |=> (odds(q2_fb_o) == odds($past(pin_i))));

  assert_observe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (observe_req_i && !lock_o && !lock_set_i) |-> (((out_o ^ q2_fb_o) & oe_i) == '0));
endmodule

bind tam_preload_ctrl tam_preload_chk #(.N_CELLS(N_CELLS)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .preload_req_i (preload_req_i),
  .observe_req_i (observe_req_i),
  .strobe_i      (strobe_i),
  .q_sel_i       (q_sel_i),
  .par_sel_i     (par_sel_i),
  .lock_set_i    (lock_set_i),
  .pin_i         (pin_i),
  .func_en_i     (func_en_i),
  .oe_i          (oe_i),
  .out_o         (out_o),
  .q1_fb_o       (q1_fb_o),
  .q2_fb_o       (q2_fb_o),
  .lock_o        (lock_o)
);

// File: tb/test_tam_preload_ctrl.sv
`timescale 1ns/1ps
module test_tam_preload_ctrl;
  localparam int N = 8;
  localparam int P = N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic preload_req = 0, observe_req = 0, strobe = 0, q_sel = 0, par_sel = 0, lock_set = 0;
  logic func_en = 0;
  logic [N-1:0] pin = '0, d1 = '0, d2 = '0, comb_sel = '0, comb = '0, inv = '0, oe = '0;
  logic [N-1:0] out, out_en, q1, q2;
  logic lock;

  logic [N-1:0] eq1, eq2;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tam_preload_ctrl #(.N_CELLS(N)) i_tam_preload_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .preload_req_i(preload_req), .observe_req_i(observe_req),
    .strobe_i(strobe), .q_sel_i(q_sel), .par_sel_i(par_sel), .lock_set_i(lock_set),
    .pin_i(pin), .func_en_i(func_en), .d1_i(d1), .d2_i(d2), .comb_sel_i(comb_sel),
    .comb_i(comb), .inv_i(inv), .oe_i(oe), .out_o(out), .out_en_o(out_en),
    .q1_fb_o(q1), .q2_fb_o(q2), .lock_o(lock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_out(input logic obs);
    logic [N-1:0] norm, m;
    norm = ((comb_sel & comb) | (~comb_sel & eq1)) ^ inv;
    m = obs ? oe : '0;
    return (eq2 & m) | (norm & ~m);
  endfunction

  task automatic check_regs(input string req);
    chk({req, " q1"}, 32'(q1), 32'(eq1));
    chk({req, " q2"}, 32'(q2), 32'(eq2));
  endtask

  // model of one accepted preload write
  task automatic model_write(input logic qs, input logic ps, input logic [N-1:0] p);
    for (int k = 0; k < P; k++) begin
      if (qs) eq2[2*k+ps] = p[2*k+1];
      else    eq1[2*k+ps] = p[2*k+1];
    end
  endtask

  task automatic strobe_pulse(input logic qs, input logic ps, input logic [N-1:0] p);
    @(negedge clk);
    q_sel = qs; par_sel = ps; pin = p; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    eq1 = '0; eq2 = '0;
    check_regs("R1 reset");
    chk("R1 lock", 32'(lock), 0);
    oe = 8'hA5;
    #0.1;
    chk("R12 oe", 32'(out_en), 32'(8'hA5));
  endtask

  task automatic t_preload_groups;
    preload_req = 1'b1;
    inv = 8'hFF; comb_sel = 8'h0F; comb = 8'h33;  // R6: must not affect stored data
    strobe_pulse(0, 0, 8'b1000_1010); model_write(0, 0, 8'b1000_1010);
    check_regs("R3 even Q1");
    strobe_pulse(0, 1, 8'b0010_1000); model_write(0, 1, 8'b0010_1000);
    check_regs("R3 odd Q1");
    strobe_pulse(1, 0, 8'b0101_0111); model_write(1, 0, 8'b0101_0111);
    check_regs("R2 R4 even Q2");
    strobe_pulse(1, 1, 8'b1101_0101); model_write(1, 1, 8'b1101_0101);
    check_regs("R3 R6 odd Q2");
    // even pins alone carry no data
    strobe_pulse(0, 0, 8'b0101_0101); model_write(0, 0, 8'b0101_0101);
    check_regs("R2 even pins ignored");
    chk("R2 even Q1 clear", 32'(q1 & 8'h55), 0);
    inv = '0; comb_sel = '0; comb = '0;
  endtask

  task automatic t_strobe_rules;
    logic [N-1:0] p0;
    p0 = 8'b1010_1010;
    @(negedge clk);
    q_sel = 0; par_sel = 1; pin = p0; strobe = 1'b1;
    model_write(0, 1, p0);
    @(negedge clk);
    pin = 8'h00;  // strobe still high
    @(negedge clk);
    check_regs("R5 held strobe writes once");
    strobe = 1'b0;
    preload_req = 1'b0;
    strobe_pulse(1, 1, 8'h00);
    @(negedge clk);
    check_regs("R5 no write without preload");
  endtask

  task automatic t_func;
    preload_req = 1'b0;
    @(negedge clk);
    func_en = 1'b1; d1 = 8'h3C; d2 = 8'hC9;
    @(negedge clk);
    func_en = 1'b0;
    eq1 = 8'h3C; eq2 = 8'hC9;
    check_regs("R11 functional load");
    comb_sel = 8'hF0; comb = 8'h96; inv = 8'h0F; observe_req = 1'b0; oe = 8'hFF;
    #0.1;
    chk("R10 normal out", 32'(out), 32'(exp_out(0)));
    @(negedge clk);
    preload_req = 1'b1; func_en = 1'b1; d1 = 8'h00; d2 = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    func_en = 1'b0; preload_req = 1'b0;
    check_regs("R11 func blocked in preload");
  endtask

  task automatic t_observe;
    @(negedge clk);
    observe_req = 1'b1; oe = 8'b1100_1010;
    #0.1;
    chk("R7 observe", 32'(out), 32'(exp_out(1)));
    chk("R12 oe observe", 32'(out_en), 32'(8'b1100_1010));
    @(negedge clk);
    oe = 8'h00;
    #0.1;
    chk("R7 oe low keeps normal", 32'(out), 32'(exp_out(0)));
    oe = 8'hFF;
  endtask

  task automatic t_lock;
    logic [N-1:0] saved1, saved2;
    preload_req = 1'b1; observe_req = 1'b1; oe = 8'hFF;
    @(negedge clk);
    lock_set = 1'b1; q_sel = 1; par_sel = 0; pin = 8'hFF; strobe = 1'b1;
    #0.1;
    chk("R9 observe blocked same cycle", 32'(out), 32'(exp_out(0)));
    @(negedge clk);
    lock_set = 1'b0; strobe = 1'b0;
    check_regs("R9 write blocked same cycle");
    chk("R8 lock set", 32'(lock), 1);
    strobe_pulse(0, 1, 8'h00);
    strobe_pulse(1, 1, 8'h00);
    @(negedge clk);
    check_regs("R8 locked preload");
    chk("R8 lock sticky", 32'(lock), 1);
    chk("R8 locked out normal", 32'(out), 32'(exp_out(0)));
    saved1 = eq1; saved2 = saved1;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    eq1 = '0; eq2 = '0;
    @(negedge clk);
    chk("R8 reset clears lock", 32'(lock), 0);
    check_regs("R1 second reset");
    strobe_pulse(1, 0, 8'hAA); model_write(1, 0, 8'hAA);
    check_regs("R8 preload after unlock");
    preload_req = 1'b0; observe_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_preload_groups();
    t_strobe_rules();
    t_func();
    t_observe();
    t_lock();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule